// File: doc/BRIEF.md
# Headroom-Tracking Supply Target Controller

This block produces the digital target code for the converter that feeds the LED anodes. After reset it ramps the code up from zero, one step at a time, to the programmed feedback code. Once that ramp is complete, it keeps each channel's cathode headroom near 1 V. It makes at most one correction in each PWM cycle.

The grayscale clock reaches the block as a single-cycle strobe, `gs_pulse`, synchronous to the system clock `clk`. An internal counter numbers these strobes within a PWM cycle of `PWM_LEN` pulses. At pulse `EVAL_IDX`, if all three channels are on, the block captures three per-channel comparator flag vectors and forms a decision:

- **Up** when any channel is below the low threshold.
- **Down** when every channel is above the high threshold.
- **Hold** otherwise.

An over-voltage flag on any channel turns an up decision into a hold. The decision is applied on pulse `EVAL_IDX+1`. The code saturates at both ends.

Top module: `anode_headroom_ctrl`

## Requirements
- R1: While `rst_n` is low, `target` is 0 and `ramp_done` is 0.
- R2: After reset, `target` rises by exactly 1 every `RAMP_DIV` clock cycles until it equals `fb_code`. `ramp_done` goes high on the next clock edge, so it is first high `fb_code*RAMP_DIV+1` edges after reset release.
- R3: While `ramp_done` is low, comparator flags and grayscale pulses have no effect on `target`. The ramp length of R2 holds even when down-requests are presented during the ramp.
- R4: Grayscale pulses are counted modulo `PWM_LEN`, starting at 0 after reset. Flags are sampled only on pulse `EVAL_IDX` (counted from 1; default 32). The result appears on the edge of pulse `EVAL_IDX+1`, and `target` is unchanged before that edge.
- R5: If any bit of `cmp_low` is 1 and no bit of `cmp_ovp` is 1, `target` increases by one.
- R6: If every bit of `cmp_high` is 1 and no bit of `cmp_low` is 1, `target` decreases by one. This holds whatever the state of `cmp_ovp`.
- R7: Any other flag combination leaves `target` unchanged.
- R8: Any `cmp_ovp` bit at 1 on the evaluation pulse blocks an upward step.
- R9: An evaluation is made only when `chan_on` is 3'b111. Otherwise `target` holds.
- R10: `target` saturates: an up step at all-ones and a down step at 0 both leave it unchanged, and it never wraps.
- R11: Once high, `ramp_done` stays high until reset, and tracking moves `target` by at most one per PWM cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gs_pulse | input | 1 | One-cycle strobe per grayscale clock rising edge |
| fb_code | input | CODE_W | Programmed feedback code that the ramp ends at |
| chan_on | input | 3 | Per-channel output-on state |
| cmp_low | input | 3 | Per-channel flag: headroom below 0.9 V |
| cmp_high | input | 3 | Per-channel flag: headroom above 1.1 V |
| cmp_ovp | input | 3 | Per-channel flag: output above 4.0 V |
| target | output | CODE_W | Supply target code |
| ramp_done | output | 1 | Soft-start complete |

## Verification
On every cycle, the assertions check four things:

- `target` moves by at most one code and never wraps across its ends.
- It never falls during the ramp.
- Outside the ramp it changes only on the apply pulse.
- `ramp_done` never drops, and an over-voltage flag at evaluation never yields an up decision.

Only the bench scenarios can show the rest: the exact ramp length, the direction chosen for each flag pattern, that flags changed between the sample and apply pulses are ignored, the all-on gating, and saturation at the code limits.

// File: rtl/anode_headroom_ctrl.sv
module anode_headroom_ctrl #(
  parameter int CODE_W   = 8,
  parameter int RAMP_DIV = 150000,
  parameter int PWM_LEN  = 4096,
  parameter int EVAL_IDX = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gs_pulse,
  input  logic [CODE_W-1:0] fb_code,
  input  logic [2:0]        chan_on,
  input  logic [2:0]        cmp_low,
  input  logic [2:0]        cmp_high,
  input  logic [2:0]        cmp_ovp,
  output logic [CODE_W-1:0] target,
  output logic              ramp_done
);

  localparam int DIV_W = (RAMP_DIV > 1) ? $clog2(RAMP_DIV) : 1;
  localparam int GS_W  = $clog2(PWM_LEN);
  localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};
  localparam logic [1:0] DIR_HOLD = 2'd0, DIR_UP = 2'd1, DIR_DN = 2'd2;

  logic [DIV_W-1:0] div_cnt;
  logic [GS_W-1:0]  gs_cnt;
  logic [1:0]       dir;

  wire sample_hit = gs_pulse && (gs_cnt == GS_W'(EVAL_IDX - 1));
  wire apply_hit  = gs_pulse && (gs_cnt == GS_W'(EVAL_IDX));
  wire all_on     = &chan_on;
  wire want_up    = (|cmp_low) && !(|cmp_ovp);
  wire want_dn    = (&cmp_high) && !(|cmp_low);
  wire step_tick  = (div_cnt == DIV_W'(RAMP_DIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)
      gs_cnt <= '0;
    else if (gs_pulse)
      gs_cnt <= (gs_cnt == GS_W'(PWM_LEN - 1)) ? '0 : gs_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      dir <= DIR_HOLD;
    else if (sample_hit)
      dir <= (!ramp_done || !all_on) ? DIR_HOLD :
             want_up ? DIR_UP : want_dn ? DIR_DN : DIR_HOLD;
    else if (apply_hit)
      dir <= DIR_HOLD;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      target    <= '0;
      ramp_done <= 1'b0;
      div_cnt   <= '0;
    end else if (!ramp_done) begin
      if (target >= fb_code)
        ramp_done <= 1'b1;
      else if (step_tick) begin
        div_cnt <= '0;
        target  <= target + 1'b1;
      end else
        div_cnt <= div_cnt + 1'b1;
    end else if (apply_hit) begin
      if (dir == DIR_UP && target != CODE_MAX)
        target <= target + 1'b1;
      else if (dir == DIR_DN && target != '0)
        target <= target - 1'b1;
    end
  end

  assert_single_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (target != $past(target)) |->
      (target == $past(target) + 1'b1) || (target == $past(target) - 1'b1));

  assert_no_wrap_top_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (target == CODE_MAX) |=> (target != '0));

  assert_no_wrap_bottom_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (target == '0) |=> (target != CODE_MAX));

  assert_ramp_monotonic_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ramp_done |=> (target >= $past(target)));

  assert_apply_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_done && !apply_hit) |=> $stable(target));

  assert_ovp_blocks_up_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_hit && |cmp_ovp) |=> (dir != DIR_UP));

  assert_done_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_done |=> ramp_done);

endmodule

// File: tb/anode_headroom_ctrl_test.sv
module anode_headroom_ctrl_test;
  localparam int W = 8, DIV = 4, LEN = 64, EV = 32;

  logic clk = 0, rst_n = 0, gs_pulse = 0;
  logic [W-1:0] fb_code = 0;
  logic [2:0] chan_on = 0, cmp_low = 0, cmp_high = 0, cmp_ovp = 0;
  logic [W-1:0] target;
  logic ramp_done;

  int n_chk = 0, n_fail = 0;
  int exp_q[$];
  string tag_q[$];
  event ev;
  int model;

  always #10 clk = ~clk;

  anode_headroom_ctrl #(.CODE_W(W), .RAMP_DIV(DIV), .PWM_LEN(LEN), .EVAL_IDX(EV)) uut (
    .clk(clk), .rst_n(rst_n), .gs_pulse(gs_pulse), .fb_code(fb_code),
    .chan_on(chan_on), .cmp_low(cmp_low), .cmp_high(cmp_high), .cmp_ovp(cmp_ovp),
    .target(target), .ramp_done(ramp_done));

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic push(string tag, int exp);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    -> ev;
  endtask

  initial forever begin
    @(ev);
    check(tag_q.pop_front(), int'(target), exp_q.pop_front());
  end

  function automatic int predict(int cur, logic [2:0] on, logic [2:0] lo,
                                 logic [2:0] hi, logic [2:0] ov);
    if (on != 3'b111) return cur;
    if (|lo && !(|ov)) return (cur == 255) ? cur : cur + 1;
    if (&hi && !(|lo)) return (cur == 0) ? cur : cur - 1;
    return cur;
  endfunction

  task automatic run_period(string tag, logic [2:0] on, logic [2:0] lo, logic [2:0] hi,
                            logic [2:0] ov, logic [2:0] lo2, logic [2:0] hi2);
    int nxt = predict(model, on, lo, hi, ov);
    for (int i = 1; i <= LEN; i++) begin
      @(negedge clk);
      chan_on = on;
      cmp_low = (i <= EV) ? lo : lo2;
      cmp_high = (i <= EV) ? hi : hi2;
      cmp_ovp = ov;
      gs_pulse = 1;
      @(negedge clk);
      gs_pulse = 0;
      if (i == EV) push({tag, " R4 no early change"}, model);
      if (i == EV + 1) push(tag, nxt);
    end
    model = nxt;
  endtask

  task automatic do_reset(int fb);
    @(negedge clk);
    rst_n = 0;
    fb_code = W'(fb);
    repeat (3) @(negedge clk);
    check("R1 reset target", int'(target), 0);
    check("R1 reset ramp_done", int'(ramp_done), 0);
    rst_n = 1;
  endtask

  task automatic ramp_len(string tag, int fb);
    int n = 0;
    while (!ramp_done && n < 5000) begin
      @(negedge clk);
      n++;
    end
    check({tag, " ramp cycles"}, n, fb * DIV + 1);
    check({tag, " ramp end code"}, int'(target), fb);
    model = fb;
  endtask

  initial begin
    #(20ns * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    do_reset(40);
    chan_on = 3'b111; cmp_high = 3'b111;
    fork
      repeat (LEN) begin
        @(negedge clk); gs_pulse = 1;
        @(negedge clk); gs_pulse = 0;
      end
      ramp_len("R2 R3", 40);
    join
    check("R11 done held", int'(ramp_done), 1);

    run_period("R5 up on low", 3'b111, 3'b010, 3'b000, 3'b000, 3'b010, 3'b000);
    run_period("R6 down all high", 3'b111, 3'b000, 3'b111, 3'b000, 3'b000, 3'b111);
    run_period("R7 hold in window", 3'b111, 3'b000, 3'b000, 3'b000, 3'b000, 3'b000);
    run_period("R7 hold partial high", 3'b111, 3'b000, 3'b101, 3'b000, 3'b000, 3'b101);
    run_period("R8 ovp blocks up", 3'b111, 3'b001, 3'b000, 3'b100, 3'b001, 3'b000);
    run_period("R6 down with ovp", 3'b111, 3'b000, 3'b111, 3'b010, 3'b000, 3'b111);
    run_period("R9 not all on", 3'b011, 3'b111, 3'b000, 3'b000, 3'b111, 3'b000);
    run_period("R4 sample edge", 3'b111, 3'b100, 3'b000, 3'b000, 3'b000, 3'b111);
    check("R11 done after tracking", int'(ramp_done), 1);

    do_reset(255);
    ramp_len("R2 full scale", 255);
    run_period("R10 saturate top", 3'b111, 3'b111, 3'b000, 3'b000, 3'b111, 3'b000);

    do_reset(0);
    ramp_len("R2 zero code", 0);
    run_period("R10 saturate bottom", 3'b111, 3'b000, 3'b111, 3'b000, 3'b000, 3'b111);

    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule